// File: doc/BRIEF.md
# Real-Time Clock Status and Control Register

This block is the register that software uses to control a real-time clock and to see its status. It sits between a simple byte-wide register bus and the timekeeping counter chain. Three event flags (watchdog expiry, alarm match, supply failure) are set by single-cycle pulses and cleared when software reads the status address. An oscillator-fail flag is decided once after power-up and stays set until software clears it. Three control bits select calibration output, write access and read capture.

A bank of holding registers shows the time to the bus. Normally the bank follows the counters on every clock. The capture bit freezes it so that a multi-byte read stays consistent. The write bit also freezes it, opens it to bus writes, and records whether any time byte was written. When the write bit is cleared, the bank is handed to the counters with a one-cycle load strobe, but only if a time byte was written. The interrupt pin carries either the interrupt request or a square wave derived from a tick input, for frequency calibration. The last time byte holds the century as two BCD digits.

Top module: `rtc_ctrl_flags`

## Requirements
- R1: Address 0 reads as {watchdog flag, alarm flag, supply-fail flag, oscillator-fail flag, 0, calibration bit, write bit, capture bit} from bit 7 down to bit 0. Address k (1..NTIME) reads holding byte k-1. Higher addresses read 0.
- R2: A pulse on a watchdog, alarm or supply-fail event input sets the matching flag at the next clock edge. The flag stays set until a read of address 0.
- R3: A read strobe on address 0 clears the three event flags at that edge. An event arriving in the same cycle as the read leaves its flag set.
- R4: After reset, all flags and control bits read 0, load_o is 0, and int_o follows irq_i.
- R5: Exactly STARTUP_CYC clock cycles after reset is released, the oscillator-fail flag is set if osc_en_i is 1 and osc_run_i is 0. Otherwise it stays 0.
- R6: The oscillator-fail flag is cleared only by a write to address 0 with bit 4 = 0 while the write bit is already 1. Status reads, writes of 1 to bit 4, and writes made while the write bit is 0 leave it unchanged.
- R7: With the calibration bit (bit 2) at 1, int_o is a square wave that toggles at each tick_i pulse. With it at 0, int_o equals irq_i.
- R8: While the write bit (bit 1) and the capture bit (bit 0) are both 0, each holding byte takes the counter value of the previous cycle.
- R9: While either the write bit or the capture bit is 1, holding bytes change only through accepted bus writes.
- R10: A write to a time address is accepted only while the write bit is 1. It updates that holding byte and marks the time as changed.
- R11: A write to address 0 with bit 1 = 0, made while the write bit is 1 and the time is marked changed, raises load_o for exactly the next cycle and clears the mark. load_time_o then holds the written bytes. If the time is not marked changed, no strobe is raised.
- R12: A write to the century byte (address NTIME) with either nibble above 9 is ignored. It neither updates the byte nor marks the time as changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears event flags at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wdt_evt_i | input | 1 | Watchdog expiry pulse |
| alarm_evt_i | input | 1 | Alarm match pulse |
| pfail_evt_i | input | 1 | Supply-fail pulse |
| osc_en_i | input | 1 | Oscillator enabled |
| osc_run_i | input | 1 | Oscillator running |
| tick_i | input | 1 | Pulse at twice the calibration frequency |
| irq_i | input | 1 | Normal interrupt request |
| cnt_time_i | input | NTIME*8 | Current counter bytes |
| load_o | output | 1 | Counter load strobe |
| load_time_o | output | NTIME*8 | Holding bytes (base time to load) |
| int_o | output | 1 | Interrupt or calibration pin |

## Verification
The holding bank is exercised in three ways. Counter patterns that change while both freeze bits are clear show that the bank follows the counters one cycle late. The same patterns changing under the capture bit show the freeze. Bus writes made while the write bit is set, and repeated while it is clear, separate accepted writes from ignored ones. Write-bit sessions are closed both with and without a prior time write, and with only a malformed century write, so that a real commit can be told apart from a spurious load strobe. Event pulses are sent alone, together, and in the same cycle as a status read, to expose whether setting or clearing wins. The oscillator check is run after two resets, one with the oscillator stopped and one with it running.

// File: rtl/rtc_cf_pkg.sv
package rtc_cf_pkg;
  localparam int FLAG_WDF  = 7;
  localparam int FLAG_AF   = 6;
  localparam int FLAG_PF   = 5;
  localparam int FLAG_OSCF = 4;
  localparam int CTL_CAL   = 2;
  localparam int CTL_W     = 1;
  localparam int CTL_R     = 0;
  localparam int NEVT      = 3;

  typedef logic [7:0] byte_t;

  function automatic logic bcd_byte_ok(input byte_t v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction
endpackage

// File: rtl/rtc_cf_evflags.sv
module rtc_cf_evflags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd_clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q, d, en;
    always_comb begin
      en = evt[g] | rd_clr;
      d  = evt[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign flag[g] = q;
  end
endmodule

// File: rtl/rtc_cf_oscmon.sv
module rtc_cf_oscmon #(
  parameter int STARTUP_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic osc_run,
  input  logic sw_clr,
  output logic oscf
);
  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, oscf_q, oscf_d;
  logic          win_end, cnt_en;

  always_comb begin
    win_end = !done_q && (cnt_q == LAST);
    cnt_en  = !done_q && !win_end;
    cnt_d   = cnt_q + 1'b1;
    if (win_end && osc_en && !osc_run) oscf_d = 1'b1;
    else if (sw_clr)                   oscf_d = 1'b0;
    else                               oscf_d = oscf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      oscf_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (win_end) done_q <= 1'b1;
      oscf_q <= oscf_d;
    end
  end

  assign oscf = oscf_q;
endmodule

// File: rtl/rtc_cf_hold.sv
module rtc_cf_hold
  import rtc_cf_pkg::*;
#(
  parameter int NTIME = 8,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze,
  input  logic               wen,
  input  logic               bus_wr,
  input  logic [AW-1:0]      addr,
  input  byte_t              wdata,
  input  logic               commit,
  input  logic [NTIME*8-1:0] cnt_time,
  output logic [NTIME*8-1:0] hold_flat,
  output logic               load
);
  logic [NTIME-1:0] wr_hit;
  logic             tchg_q, tchg_d, load_d;

  for (genvar g = 0; g < NTIME; g++) begin : g_byte
    logic  ok, en;
    byte_t q, d;
    if (g == NTIME - 1) begin : g_century
      assign ok = bcd_byte_ok(wdata);
    end else begin : g_plain
      assign ok = 1'b1;
    end
    always_comb begin
      wr_hit[g] = bus_wr && wen && ok && (addr == AW'(g + 1));
      en        = !freeze || wr_hit[g];
      d         = freeze ? wdata : cnt_time[g*8 +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign hold_flat[g*8 +: 8] = q;
  end

  always_comb begin
    load_d = commit && tchg_q;
    if (|wr_hit)     tchg_d = 1'b1;
    else if (commit) tchg_d = 1'b0;
    else             tchg_d = tchg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tchg_q <= 1'b0;
      load   <= 1'b0;
    end else begin
      tchg_q <= tchg_d;
      load   <= load_d;
    end
  end
endmodule

// File: rtl/rtc_cf_pin.sv
module rtc_cf_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cal,
  input  logic irq,
  output logic pin
);
  logic sq_q, sq_d;

  always_comb sq_d = ~sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sq_q <= 1'b0;
    else if (tick) sq_q <= sq_d;
  end

  assign pin = cal ? sq_q : irq;
endmodule

// File: rtl/rtc_ctrl_flags.sv
module rtc_ctrl_flags
  import rtc_cf_pkg::*;
#(
  parameter  int NTIME       = 8,
  parameter  int STARTUP_CYC = 500000,
  localparam int AW          = $clog2(NTIME + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               wdt_evt_i,
  input  logic               alarm_evt_i,
  input  logic               pfail_evt_i,
  input  logic               osc_en_i,
  input  logic               osc_run_i,
  input  logic               tick_i,
  input  logic               irq_i,
  input  logic [NTIME*8-1:0] cnt_time_i,
  output logic               load_o,
  output logic [NTIME*8-1:0] load_time_o,
  output logic               int_o
);
  logic [1:0]      rs_q;
  logic            rst_s_n;
  logic            sel_flags, wr_flags, rd_flags;
  logic            cal_q, w_q, r_q;
  logic            commit, osc_clr, oscf;
  logic [NEVT-1:0] evt_in, evt_flag;
  logic [NTIME*8-1:0] hold_flat;
  byte_t           flags_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  always_comb begin
    sel_flags = (bus_addr == '0);
    wr_flags  = bus_wr && sel_flags;
    rd_flags  = bus_rd && sel_flags;
    commit    = wr_flags && w_q && !bus_wdata[CTL_W];
    osc_clr   = wr_flags && w_q && !bus_wdata[FLAG_OSCF];
    evt_in    = {wdt_evt_i, alarm_evt_i, pfail_evt_i};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cal_q <= 1'b0;
      w_q   <= 1'b0;
      r_q   <= 1'b0;
    end else if (wr_flags) begin
      cal_q <= bus_wdata[CTL_CAL];
      w_q   <= bus_wdata[CTL_W];
      r_q   <= bus_wdata[CTL_R];
    end
  end

  rtc_cf_evflags #(.N(NEVT)) u_evflags (
    .clk(clk), .rst_n(rst_s_n), .evt(evt_in), .rd_clr(rd_flags), .flag(evt_flag)
  );

  rtc_cf_oscmon #(.STARTUP_CYC(STARTUP_CYC)) u_oscmon (
    .clk(clk), .rst_n(rst_s_n), .osc_en(osc_en_i), .osc_run(osc_run_i),
    .sw_clr(osc_clr), .oscf(oscf)
  );

  rtc_cf_hold #(.NTIME(NTIME), .AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_s_n), .freeze(w_q || r_q), .wen(w_q), .bus_wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .commit(commit), .cnt_time(cnt_time_i),
    .hold_flat(hold_flat), .load(load_o)
  );

  rtc_cf_pin u_pin (
    .clk(clk), .rst_n(rst_s_n), .tick(tick_i), .cal(cal_q), .irq(irq_i), .pin(int_o)
  );

  always_comb begin
    flags_byte            = '0;
    flags_byte[FLAG_WDF]  = evt_flag[2];
    flags_byte[FLAG_AF]   = evt_flag[1];
    flags_byte[FLAG_PF]   = evt_flag[0];
    flags_byte[FLAG_OSCF] = oscf;
    flags_byte[CTL_CAL]   = cal_q;
    flags_byte[CTL_W]     = w_q;
    flags_byte[CTL_R]     = r_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_flags) bus_rdata = flags_byte;
    for (int i = 0; i < NTIME; i++) begin
      if (bus_addr == AW'(i + 1)) bus_rdata = hold_flat[i*8 +: 8];
    end
  end

  assign load_time_o = hold_flat;
endmodule

// File: rtl/rtc_ctrl_flags_chk.sv
module rtc_ctrl_flags_chk #(
  parameter int NTIME = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               w_q,
  input logic               r_q,
  input logic [NTIME*8-1:0] hold_flat,
  input logic [NTIME*8-1:0] cnt_time_i,
  input logic               load_o,
  input logic               wdt_evt_i,
  input logic               rd_flags,
  input logic               wdf
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R11
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R11
  load_after_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && load_o) |-> ($past(w_q) && !w_q));

  // R8
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(w_q) && !$past(r_q)) |-> (hold_flat == $past(cnt_time_i)));

  // R9
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(r_q) && !$past(w_q)) |-> $stable(hold_flat));

  // R2
  wdf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(wdt_evt_i)) |-> wdf);

  // R3
  wdf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(rd_flags) && !$past(wdt_evt_i)) |-> !wdf);
endmodule

bind rtc_ctrl_flags rtc_ctrl_flags_chk #(.NTIME(NTIME)) chk_i (
  .clk(clk), .rst_n(rst_s_n), .w_q(w_q), .r_q(r_q), .hold_flat(hold_flat),
  .cnt_time_i(cnt_time_i), .load_o(load_o), .wdt_evt_i(wdt_evt_i),
  .rd_flags(rd_flags), .wdf(evt_flag[2])
);

// File: tb/rtc_ctrl_flags_tb_top.sv
module rtc_ctrl_flags_tb_top;
  localparam int NTIME = 8;
  localparam int SCYC  = 20;
  localparam int AW    = $clog2(NTIME + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic wdt = 1'b0, alm = 1'b0, pf = 1'b0;
  logic osc_en = 1'b1, osc_run = 1'b0, tick = 1'b0, irq = 1'b0;
  logic [NTIME*8-1:0] cnt_time = '0, load_time;
  logic load, int_pin;

  rtc_ctrl_flags #(.NTIME(NTIME), .STARTUP_CYC(SCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_evt_i(wdt), .alarm_evt_i(alm),
    .pfail_evt_i(pf), .osc_en_i(osc_en), .osc_run_i(osc_run), .tick_i(tick), .irq_i(irq),
    .cnt_time_i(cnt_time), .load_o(load), .load_time_o(load_time), .int_o(int_pin)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [1:0] m_sync;
  bit m_wdf, m_af, m_pf, m_oscf, m_cal, m_w, m_r, m_tchg, m_load, m_sq, m_done;
  int m_cyc;
  logic [7:0] m_hold [NTIME];

  task automatic m_clear();
    {m_wdf, m_af, m_pf, m_oscf, m_cal, m_w, m_r, m_tchg, m_load, m_sq, m_done} = '0;
    m_cyc = 0;
    foreach (m_hold[i]) m_hold[i] = 8'h00;
  endtask

  task automatic m_step();
    bit ow, orr, rd0, wr0;
    int idx;
    ow = m_w; orr = m_r;
    rd0 = bus_rd && (bus_addr == 0);
    wr0 = bus_wr && (bus_addr == 0);
    m_wdf = wdt || (m_wdf && !rd0);
    m_af  = alm || (m_af && !rd0);
    m_pf  = pf  || (m_pf && !rd0);
    if (wr0 && ow && !bus_wdata[4]) m_oscf = 0;
    if (!m_done) begin
      if (m_cyc == SCYC - 1) begin
        m_done = 1;
        if (osc_en && !osc_run) m_oscf = 1;
      end else m_cyc++;
    end
    if (tick) m_sq = !m_sq;
    m_load = 0;
    if (wr0 && ow && !bus_wdata[1] && m_tchg) begin
      m_load = 1;
      m_tchg = 0;
    end
    if (!ow && !orr) begin
      for (int i = 0; i < NTIME; i++) m_hold[i] = cnt_time[i*8 +: 8];
    end else if (ow && bus_wr && bus_addr >= 1 && bus_addr <= NTIME) begin
      idx = int'(bus_addr) - 1;
      if (idx != NTIME - 1 || (bus_wdata[7:4] < 10 && bus_wdata[3:0] < 10)) begin
        m_hold[idx] = bus_wdata;
        m_tchg = 1;
      end
    end
    if (wr0) begin
      m_cal = bus_wdata[2];
      m_w   = bus_wdata[1];
      m_r   = bus_wdata[0];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00;
      m_clear();
    end else begin
      if (m_sync[1]) m_step();
      m_sync = {m_sync[0], 1'b1};
    end
  end

  always @(posedge clk) cycles++;

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    logic [7:0] exp_rd;
    logic [NTIME*8-1:0] exp_lt;
    #3;
    if (cycles > 2) begin
      exp_rd = 8'h00;
      if (bus_addr == 0) exp_rd = {m_wdf, m_af, m_pf, m_oscf, 1'b0, m_cal, m_w, m_r};
      else if (bus_addr <= NTIME) exp_rd = m_hold[int'(bus_addr) - 1];
      for (int i = 0; i < NTIME; i++) exp_lt[i*8 +: 8] = m_hold[i];
      check("R1 model rdata", 64'(bus_rdata), 64'(exp_rd));
      check("R11 model load", 64'(load), 64'(m_load));
      check("R11 model load_time", 64'(load_time), 64'(exp_lt));
      check("R7 model int", 64'(int_pin), 64'(m_cal ? m_sq : irq));
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    #3 check(req, 64'(bus_rdata), 64'(exp));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic w_, input logic a_, input logic p_);
    @(negedge clk);
    wdt = w_; alm = a_; pf = p_;
    @(negedge clk);
    wdt = 1'b0; alm = 1'b0; pf = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R4 reset state
    rd_chk(0, 8'h00, "R4 flags after reset");
    #3 check("R4 load after reset", 64'(load), 64'h0);
    // R5 oscillator stopped at end of window
    repeat (30) @(negedge clk);
    rd_chk(0, 8'h10, "R5 oscf set");
    // R6 clear rules
    wr(0, 8'h00);
    rd_chk(0, 8'h10, "R6 clear ignored with write bit 0");
    wr(0, 8'h02);
    rd_chk(0, 8'h12, "R6 oscf kept on enabling write");
    wr(0, 8'h12);
    rd_chk(0, 8'h12, "R6 writing 1 keeps oscf");
    wr(0, 8'h02);
    rd_chk(0, 8'h02, "R6 oscf cleared");
    wr(0, 8'h00);
    #3 check("R11 no load without time write", 64'(load), 64'h0);
    // R2 / R3 event flags
    pulse_evt(1'b1, 1'b1, 1'b0);
    rd_chk(0, 8'hC0, "R2 watchdog and alarm set");
    rd_chk(0, 8'h00, "R3 cleared by read");
    @(negedge clk);
    bus_addr = '0; bus_rd = 1'b1; pf = 1'b1;
    #3 check("R3 read before same-cycle event", 64'(bus_rdata), 64'h00);
    @(negedge clk);
    bus_rd = 1'b0; pf = 1'b0;
    rd_chk(0, 8'h20, "R3 same-cycle event survives read");
    rd_chk(0, 8'h00, "R3 cleared afterwards");
    // R8 follow
    @(negedge clk) cnt_time = 64'h0807060504030201;
    repeat (2) @(negedge clk);
    rd_chk(1, 8'h01, "R8 byte0 follows");
    rd_chk(8, 8'h08, "R8 century follows");
    rd_chk(9, 8'h00, "R1 unmapped address");
    // R9 capture
    wr(0, 8'h01);
    @(negedge clk) cnt_time = 64'h1817161514131211;
    repeat (3) @(negedge clk);
    rd_chk(1, 8'h01, "R9 captured");
    rd_chk(0, 8'h01, "R1 capture bit position");
    wr(1, 8'h77);
    rd_chk(1, 8'h01, "R10 write ignored with write bit 0");
    wr(0, 8'h00);
    repeat (2) @(negedge clk);
    rd_chk(1, 8'h11, "R8 follows after capture released");
    // R10 / R11 / R12 commit
    wr(0, 8'h02);
    @(negedge clk) cnt_time = 64'h2827262524232221;
    wr(1, 8'h45);
    wr(8, 8'h19);
    wr(8, 8'h1A);
    rd_chk(8, 8'h19, "R12 bad century ignored");
    rd_chk(1, 8'h45, "R10 write accepted");
    rd_chk(2, 8'h12, "R9 frozen under write bit");
    wr(0, 8'h00);
    #3;
    check("R11 load strobe", 64'(load), 64'h1);
    check("R11 load byte0", 64'(load_time[7:0]), 64'h45);
    check("R11 load century", 64'(load_time[63:56]), 64'h19);
    @(negedge clk);
    #3 check("R11 strobe one cycle", 64'(load), 64'h0);
    wr(0, 8'h02);
    wr(8, 8'hA0);
    wr(0, 8'h00);
    #3 check("R12 bad century marks nothing", 64'(load), 64'h0);
    // R7 pin
    @(negedge clk) irq = 1'b1;
    #3 check("R7 irq passes", 64'(int_pin), 64'h1);
    @(negedge clk) irq = 1'b0;
    #3 check("R7 irq low", 64'(int_pin), 64'h0);
    wr(0, 8'h04);
    for (int k = 0; k < 3; k++) begin
      #1 v0 = int_pin;
      @(negedge clk) tick = 1'b1; irq = 1'b1;
      @(negedge clk) tick = 1'b0; irq = 1'b0;
      #3 check("R7 square wave toggles", 64'(int_pin), 64'(!v0));
    end
    // R1 full layout
    wr(0, 8'h07);
    pulse_evt(1'b1, 1'b0, 1'b0);
    rd_chk(0, 8'h87, "R1 layout");
    wr(0, 8'h00);
    // R5 oscillator running
    osc_run = 1'b1;
    do_reset();
    repeat (30) @(negedge clk);
    rd_chk(0, 8'h00, "R5 oscf stays clear when running");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule